// File: doc/BRIEF.md
# Serial Receiver/Transmitter with Error Status and Bit-Order Select

This block is one asynchronous serial channel. A byte written to the transmit holding register is moved into a transmit shift register as soon as the shifter is idle. It is then sent as a start bit, eight data bits, an optional parity bit and a stop bit. Incoming frames are sampled at mid-bit with 16x oversampling. Each completed frame is placed in a receive holding register. Any parity, framing or overrun condition is recorded in sticky flags.

Software reaches the block through a small register bus. Address 0 reads the received byte and writes the byte to send. Address 1 reads status, and a write there sets the bit-order select. Address 2 holds the control bits. The first-bit order is applied by reversing the byte at the moment the data register is accessed. Two level-sensitive interrupt requests, one for receive and one for transmit, come out of the block. A 16x baud clock-enable is supplied from outside.

Top module: `uart_stat_core`

## Requirements
- R1: After reset the status word reads 0x0800 (only transmit-empty set), both interrupt requests are low and `txd` is high.
- R2: The status word at address 1 holds these bits, with all other bits 0:
  - bit 15: parity error
  - bit 14: overrun
  - bit 13: framing error
  - bit 12: receive-full
  - bit 11: transmit-empty
  - bit 10: bit-order select
- R3: A transmitted frame on `txd` is a 0 start bit, 8 data bits, a parity bit when parity is enabled, and a 1 stop bit. Each bit lasts 16 `baud_tick` pulses.
- R4: Transmit-empty goes to 0 on a write to address 0. It returns to 1 when that byte is moved into the idle shifter. While a frame is being sent, a second write keeps it 0 until that frame ends.
- R5: Receive-full goes to 1 when a received byte is loaded into the receive register. A read of address 0 clears it.
- R6: With the bit-order select at 0, bytes go out and come in LSB first; with 1, MSB first. Reversal is applied at the time of the data-register read or write. A change of the select between reception and read therefore reverses the byte returned.
- R7: Control bit 3 enables parity and control bit 4 picks odd parity (0 = even). A received parity bit that does not match sets the parity error flag.
- R8: A stop bit sampled as 0 sets the framing error flag.
- R9: A frame that completes while receive-full is 1 sets the overrun flag and is discarded. The receive register keeps the older byte.
- R10: Writing address 2 with bit 0 at 0 clears all three error flags together. Writing it with bit 0 at 1 leaves them unchanged.
- R11: `irq_rx` is high exactly when control bit 1 is 1 and at least one of the three error flags or receive-full is 1.
- R12: `irq_tx` is high exactly when control bit 2 is 1 and transmit-empty is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Read data, combinational from `addr` |
| irq_rx | output | 1 | Receive interrupt request (level) |
| irq_tx | output | 1 | Transmit interrupt request (level) |

## Verification
The assertions assume that a data-register read and a receive frame never complete in the same cycle. They also assume that an error-clearing control write never lands in the cycle a frame finishes. The stimulus keeps to both by issuing register accesses only after each frame has been fully driven and an idle bit time has passed. The checks on the error flags' sticky behaviour rest on the bus being the only source of a clear. The bench therefore performs every clear through a control write whose bit 0 it chooses explicitly.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;

    localparam logic [1:0] ADR_DATA = 2'd0;
    localparam logic [1:0] ADR_STAT = 2'd1;
    localparam logic [1:0] ADR_CTRL = 2'd2;

    // status bit positions
    localparam int unsigned ST_PE   = 15;
    localparam int unsigned ST_ORE  = 14;
    localparam int unsigned ST_FRE  = 13;
    localparam int unsigned ST_FULL = 12;
    localparam int unsigned ST_EMPT = 11;
    localparam int unsigned ST_DIR  = 10;

    // control bit positions
    localparam int unsigned CT_CLRN = 0;
    localparam int unsigned CT_RIE  = 1;
    localparam int unsigned CT_TIE  = 2;
    localparam int unsigned CT_PEN  = 3;
    localparam int unsigned CT_PODD = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_e;

endpackage

// File: rtl/uart_stat_tx.sv
module uart_stat_tx
    import uart_stat_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [DATA_W-1:0] data,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              busy,
    output logic              txd
);

    localparam int unsigned CNT_W = $clog2(OSR);
    localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              pbit;
        logic              line;
    } tx_t;

    tx_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.ph == PH_IDLE) begin
            st_d.line = 1'b1;
            if (start) begin
                st_d.ph   = PH_START;
                st_d.sh   = data;
                st_d.pbit = (^data) ^ par_odd;
                st_d.cnt  = '0;
                st_d.line = 1'b0;
            end
        end else if (tick) begin
            if (st_q.cnt != CNT_LAST) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.cnt = '0;
                unique case (st_q.ph)
                    PH_START: begin
                        st_d.ph   = PH_DATA;
                        st_d.idx  = '0;
                        st_d.line = st_q.sh[0];
                    end
                    PH_DATA: begin
                        if (st_q.idx == IDX_LAST) begin
                            st_d.ph   = par_en ? PH_PAR : PH_STOP;
                            st_d.line = par_en ? st_q.pbit : 1'b1;
                        end else begin
                            st_d.idx  = st_q.idx + 1'b1;
                            st_d.sh   = st_q.sh >> 1;
                            st_d.line = st_q.sh[1];
                        end
                    end
                    PH_PAR: begin
                        st_d.ph   = PH_STOP;
                        st_d.line = 1'b1;
                    end
                    default: begin
                        st_d.ph   = PH_IDLE;
                        st_d.line = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ph   <= PH_IDLE;
            st_q.line <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.ph != PH_IDLE);
    assign txd  = st_q.line;

endmodule

// File: rtl/uart_stat_rx.sv
module uart_stat_rx
    import uart_stat_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              done,
    output logic [DATA_W-1:0] word,
    output logic              perr,
    output logic              ferr
);

    localparam int unsigned CNT_W = $clog2(OSR);
    localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OSR / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    typedef struct packed {
        logic              s1;
        logic              s2;
        logic              s3;
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] sh;
        logic              perr;
        logic              ferr;
        logic              done;
    } rx_t;

    rx_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = rxd;
        st_d.s2   = st_q.s1;
        st_d.s3   = st_q.s2;
        st_d.done = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (st_q.s3 && !st_q.s2) begin
                    st_d.ph  = PH_START;
                    st_d.cnt = '0;
                end
            end
            PH_START: begin
                if (tick) begin
                    if (st_q.cnt == CNT_MID) begin
                        st_d.cnt  = '0;
                        st_d.idx  = '0;
                        st_d.perr = 1'b0;
                        st_d.ph   = st_q.s2 ? PH_IDLE : PH_DATA;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_DATA: begin
                if (tick) begin
                    if (st_q.cnt == CNT_LAST) begin
                        st_d.cnt = '0;
                        st_d.sh  = {st_q.s2, st_q.sh[DATA_W-1:1]};
                        if (st_q.idx == IDX_LAST) begin
                            st_d.ph = par_en ? PH_PAR : PH_STOP;
                        end else begin
                            st_d.idx = st_q.idx + 1'b1;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            PH_PAR: begin
                if (tick) begin
                    if (st_q.cnt == CNT_LAST) begin
                        st_d.cnt  = '0;
                        st_d.perr = (^st_q.sh) ^ st_q.s2 ^ par_odd;
                        st_d.ph   = PH_STOP;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (st_q.cnt == CNT_LAST) begin
                        st_d.cnt  = '0;
                        st_d.ferr = !st_q.s2;
                        st_d.done = 1'b1;
                        st_d.ph   = PH_IDLE;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.s1 <= 1'b1;
            st_q.s2 <= 1'b1;
            st_q.s3 <= 1'b1;
            st_q.ph <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign done = st_q.done;
    assign word = st_q.sh;
    assign perr = st_q.perr;
    assign ferr = st_q.ferr;

endmodule

// File: rtl/uart_stat_core.sv
module uart_stat_core
    import uart_stat_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OSR    = 16,
    parameter int unsigned BUS_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             baud_tick,
    input  logic             rxd,
    output logic             txd,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             irq_rx,
    output logic             irq_tx
);

    typedef struct packed {
        logic [DATA_W-1:0] tx_buf;
        logic              empt;
        logic [DATA_W-1:0] rx_buf;
        logic              full;
        logic              pe;
        logic              ore;
        logic              fre;
        logic              dir;
        logic              rie;
        logic              tie;
        logic              pen;
        logic              podd;
    } regs_t;

    regs_t rg_d, rg_q;

    logic              tx_busy;
    logic              tx_start;
    logic              rx_done;
    logic [DATA_W-1:0] rx_word;
    logic              rx_perr;
    logic              rx_ferr;
    logic [DATA_W-1:0] wr_rev;
    logic [DATA_W-1:0] rd_rev;
    logic [DATA_W-1:0] rx_buf_w;
    logic [BUS_W-1:0]  status_w;
    logic              data_wr;
    logic              data_rd;

    // bit-order reversal network, applied on the register access path
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign wr_rev[i] = wdata[DATA_W-1-i];
        assign rd_rev[i] = rg_q.rx_buf[DATA_W-1-i];
    end

    assign data_wr  = wr_en && (addr == ADR_DATA);
    assign data_rd  = rd_en && (addr == ADR_DATA);
    assign tx_start = !rg_q.empt && !tx_busy;
    assign rx_buf_w = rg_q.rx_buf;

    uart_stat_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (baud_tick),
        .start   (tx_start),
        .data    (rg_q.tx_buf),
        .par_en  (rg_q.pen),
        .par_odd (rg_q.podd),
        .busy    (tx_busy),
        .txd     (txd)
    );

    uart_stat_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (baud_tick),
        .rxd     (rxd),
        .par_en  (rg_q.pen),
        .par_odd (rg_q.podd),
        .done    (rx_done),
        .word    (rx_word),
        .perr    (rx_perr),
        .ferr    (rx_ferr)
    );

    always_comb begin
        rg_d = rg_q;
        // transmit hand-over
        if (tx_start) begin
            rg_d.empt = 1'b1;
        end
        if (data_wr) begin
            rg_d.tx_buf = rg_q.dir ? wr_rev : wdata[DATA_W-1:0];
            rg_d.empt   = 1'b0;
        end
        // register writes
        if (wr_en && (addr == ADR_STAT)) begin
            rg_d.dir = wdata[ST_DIR];
        end
        if (wr_en && (addr == ADR_CTRL)) begin
            rg_d.rie  = wdata[CT_RIE];
            rg_d.tie  = wdata[CT_TIE];
            rg_d.pen  = wdata[CT_PEN];
            rg_d.podd = wdata[CT_PODD];
            if (!wdata[CT_CLRN]) begin
                rg_d.pe  = 1'b0;
                rg_d.ore = 1'b0;
                rg_d.fre = 1'b0;
            end
        end
        // receive side
        if (data_rd) begin
            rg_d.full = 1'b0;
        end
        if (rx_done) begin
            if (rg_q.full && !data_rd) begin
                rg_d.ore = 1'b1;
            end else begin
                rg_d.rx_buf = rx_word;
                rg_d.full   = 1'b1;
                rg_d.pe     = rg_q.pe | rx_perr;
                rg_d.fre    = rg_q.fre | rx_ferr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q      <= '0;
            rg_q.empt <= 1'b1;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        status_w          = '0;
        status_w[ST_PE]   = rg_q.pe;
        status_w[ST_ORE]  = rg_q.ore;
        status_w[ST_FRE]  = rg_q.fre;
        status_w[ST_FULL] = rg_q.full;
        status_w[ST_EMPT] = rg_q.empt;
        status_w[ST_DIR]  = rg_q.dir;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADR_DATA: rdata[DATA_W-1:0] = rg_q.dir ? rd_rev : rg_q.rx_buf;
            ADR_STAT: rdata = status_w;
            ADR_CTRL: begin
                rdata[CT_CLRN] = 1'b1;
                rdata[CT_RIE]  = rg_q.rie;
                rdata[CT_TIE]  = rg_q.tie;
                rdata[CT_PEN]  = rg_q.pen;
                rdata[CT_PODD] = rg_q.podd;
            end
            default: rdata = '0;
        endcase
    end

    assign irq_rx = rg_q.rie & (rg_q.pe | rg_q.ore | rg_q.fre | rg_q.full);
    assign irq_tx = rg_q.tie & rg_q.empt;

endmodule

// File: rtl/uart_stat_chk.sv
module uart_stat_chk
    import uart_stat_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned BUS_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [1:0]        addr,
    input logic [BUS_W-1:0]  wdata,
    input logic [BUS_W-1:0]  status,
    input logic              irq_rx,
    input logic              irq_tx,
    input logic              rx_done,
    input logic              tx_start,
    input logic [DATA_W-1:0] rx_buf
);

    AST_EMPTY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADR_DATA) |=> !status[ST_EMPT]); // R4

    AST_EMPTY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_EMPT]) |-> $past(tx_start)); // R4

    AST_FULL_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADR_DATA && !rx_done) |=> !status[ST_FULL]); // R5

    AST_PE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[ST_PE]) |-> $past(wr_en && addr == ADR_CTRL && !wdata[CT_CLRN])); // R10

    AST_ORE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[ST_ORE]) |-> $past(wr_en && addr == ADR_CTRL && !wdata[CT_CLRN])); // R10

    AST_FRE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[ST_FRE]) |-> $past(wr_en && addr == ADR_CTRL && !wdata[CT_CLRN])); // R10

    AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_ORE]) |-> $stable(rx_buf)); // R9

    AST_RX_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rx |-> (|status[ST_PE:ST_FULL])); // R11

    AST_TX_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> status[ST_EMPT]); // R12

endmodule

bind uart_stat_core uart_stat_chk #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .status   (status_w),
    .irq_rx   (irq_rx),
    .irq_tx   (irq_tx),
    .rx_done  (rx_done),
    .tx_start (tx_start),
    .rx_buf   (rx_buf_w)
);

// File: tb/tb_uart_stat_core.sv
module tb_uart_stat_core;

    localparam int BIT_CLK = 64; // 16 ticks of one tick per 4 clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        baud_tick = 1'b0;
    logic        rxd = 1'b1;
    logic        txd;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq_rx;
    logic        irq_tx;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit cmp_en = 0;

    // reference model state
    bit m_pe, m_ore, m_fre, m_full, m_empt, m_dir, m_rie, m_tie;
    logic [7:0] m_rxbuf;

    logic [7:0] mon_byte [2];
    logic       mon_par;
    logic       mon_stop;

    uart_stat_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .rxd       (rxd),
        .txd       (txd),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .irq_rx    (irq_rx),
        .irq_tx    (irq_tx)
    );

    always #4 clk = ~clk;

    int tcnt = 0;
    always @(posedge clk) begin
        tcnt      <= (tcnt + 1) % 4;
        baud_tick <= (tcnt == 3);
    end

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    function automatic logic [15:0] m_status();
        return {m_pe, m_ore, m_fre, m_full, m_empt, m_dir, 10'd0};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-clock comparison of the interrupt lines against the model
    always @(posedge clk) begin
        #2;
        if (cmp_en && rst_n && !finished) begin
            chk(irq_rx == ((m_pe | m_ore | m_fre | m_full) & m_rie), "R11 irq_rx", irq_rx,
                (m_pe | m_ore | m_fre | m_full) & m_rie);
            chk(irq_tx == (m_empt & m_tie), "R12 irq_tx", irq_tx, m_empt & m_tie);
        end
    end

    task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1;
        if (a == 2'd2) begin
            m_rie = d[1]; m_tie = d[2];
            if (!d[0]) begin m_pe = 0; m_ore = 0; m_fre = 0; end
        end else if (a == 2'd1) begin
            m_dir = d[10];
        end else if (a == 2'd0) begin
            m_empt = 0;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(posedge clk);
        #1;
        if (a == 2'd0) m_full = 0;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b, input bit pen, input bit podd,
                           input bit bad_par, input bit bad_stop);
        logic p;
        p = (^b) ^ podd ^ bad_par;
        cmp_en = 0;
        @(negedge clk); rxd = 1'b0;
        repeat (BIT_CLK) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BIT_CLK) @(negedge clk);
        end
        if (pen) begin
            rxd = p;
            repeat (BIT_CLK) @(negedge clk);
        end
        rxd = !bad_stop;
        repeat (BIT_CLK) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT_CLK) @(negedge clk);
        if (m_full) begin
            m_ore = 1;
        end else begin
            m_full = 1; m_rxbuf = b;
            m_pe = m_pe | (pen & bad_par);
            m_fre = m_fre | bad_stop;
        end
        cmp_en = 1;
    endtask

    task automatic mon_tx(input int slot, input bit pen);
        logic [7:0] b;
        @(negedge txd);
        repeat (BIT_CLK / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (BIT_CLK) @(negedge clk);
            b[i] = txd;
        end
        if (pen) begin
            repeat (BIT_CLK) @(negedge clk);
            mon_par = txd;
        end
        repeat (BIT_CLK) @(negedge clk);
        mon_stop = txd;
        mon_byte[slot] = b;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        m_pe = 0; m_ore = 0; m_fre = 0; m_full = 0; m_empt = 1;
        m_dir = 0; m_rie = 0; m_tie = 0; m_rxbuf = '0;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        cmp_en = 1;

        // R1 / R2 reset state
        bus_rd(2'd1, r);
        chk(r == 16'h0800, "R1 R2 reset status", r, 16'h0800);
        chk(txd == 1'b1 && irq_rx == 0 && irq_tx == 0, "R1 idle outputs",
            {txd, irq_rx, irq_tx}, 3'b100);

        // enable both interrupts, no clear
        bus_wr(2'd2, 16'h0007);
        @(negedge clk);
        chk(irq_tx == 1'b1, "R12 tx request when empty", irq_tx, 1);

        // R3 R4: two back-to-back bytes LSB first
        cmp_en = 0;
        fork
            begin mon_tx(0, 0); mon_tx(1, 0); end
            begin
                bus_wr(2'd0, 16'h00A5);
                repeat (4) @(negedge clk);
                bus_wr(2'd0, 16'h0011);
                bus_rd(2'd1, r);
                chk(r[11] == 1'b0, "R4 empty stays 0 while shifter busy", r[11], 0);
                chk(irq_tx == 1'b0, "R12 no tx request while pending", irq_tx, 0);
            end
        join
        m_empt = 1;
        chk(mon_byte[0] == 8'hA5, "R3 first frame data", mon_byte[0], 8'hA5);
        chk(mon_byte[1] == 8'h11, "R3 second frame data", mon_byte[1], 8'h11);
        chk(mon_stop == 1'b1, "R3 stop bit", mon_stop, 1);
        bus_rd(2'd1, r);
        chk(r[11] == 1'b1, "R4 empty after hand-over", r[11], 1);
        cmp_en = 1;

        // R6 R7: MSB first with even parity
        bus_wr(2'd1, 16'h0400);
        bus_wr(2'd2, 16'h000F);
        cmp_en = 0;
        fork
            mon_tx(0, 1);
            bus_wr(2'd0, 16'h001C);
        join
        m_empt = 1;
        chk(mon_byte[0] == rev8(8'h1C), "R6 MSB-first transmit order", mon_byte[0], rev8(8'h1C));
        chk(mon_par == 1'b1, "R7 even parity bit sent", mon_par, 1);
        repeat (BIT_CLK) @(negedge clk);
        cmp_en = 1;
        bus_wr(2'd1, 16'h0000);
        bus_wr(2'd2, 16'h0007);

        // R5 receive LSB first
        send_rx(8'h5A, 0, 0, 0, 0);
        bus_rd(2'd1, r);
        chk(r == 16'h1800, "R5 full after receive", r, 16'h1800);
        chk(irq_rx == 1'b1, "R11 rx request on data", irq_rx, 1);
        bus_rd(2'd0, r);
        chk(r == 16'h005A, "R5 received data", r, 16'h005A);
        bus_rd(2'd1, r);
        chk(r == 16'h0800, "R5 full cleared by read", r, 16'h0800);

        // R6 reversal at access time
        send_rx(8'h12, 0, 0, 0, 0);
        bus_wr(2'd1, 16'h0400);
        bus_rd(2'd0, r);
        chk(r == {8'h00, rev8(8'h12)}, "R6 reversal applied on read", r, rev8(8'h12));
        bus_wr(2'd1, 16'h0000);

        // R9 overrun
        send_rx(8'h33, 0, 0, 0, 0);
        send_rx(8'h44, 0, 0, 0, 0);
        bus_rd(2'd1, r);
        chk(r == 16'h5800, "R9 overrun flagged", r, 16'h5800);
        bus_rd(2'd0, r);
        chk(r == 16'h0033, "R9 older byte kept", r, 16'h0033);

        // R10 clear semantics
        bus_wr(2'd2, 16'h0007);
        bus_rd(2'd1, r);
        chk(r == 16'h4800, "R10 clear bit 1 has no effect", r, 16'h4800);
        bus_wr(2'd2, 16'h0006);
        bus_rd(2'd1, r);
        chk(r == 16'h0800, "R10 clear bit 0 clears errors", r, 16'h0800);

        // R7 parity error, even then odd
        bus_wr(2'd2, 16'h000F);
        send_rx(8'h07, 1, 0, 1, 0);
        bus_rd(2'd1, r);
        chk(r == 16'h9800, "R7 parity error flagged", r, 16'h9800);
        bus_rd(2'd0, r);
        bus_wr(2'd2, 16'h001E);
        send_rx(8'h07, 1, 1, 0, 0);
        bus_rd(2'd1, r);
        chk(r == 16'h1800, "R7 odd parity accepted", r, 16'h1800);
        bus_rd(2'd0, r);
        chk(r == 16'h0007, "R7 odd parity data", r, 16'h0007);

        // R8 framing error
        bus_wr(2'd2, 16'h0007);
        send_rx(8'h55, 0, 0, 0, 1);
        bus_rd(2'd1, r);
        chk(r == 16'h3800, "R8 framing error flagged", r, 16'h3800);
        bus_rd(2'd0, r);
        bus_wr(2'd2, 16'h0006);

        // R11 R12 requests masked by enables
        bus_wr(2'd2, 16'h0001);
        send_rx(8'h66, 0, 0, 0, 0);
        @(negedge clk);
        chk(irq_rx == 1'b0, "R11 rx request masked", irq_rx, 0);
        chk(irq_tx == 1'b0, "R12 tx request masked", irq_tx, 0);
        bus_rd(2'd0, r);
        chk(r == 16'h0066, "R5 data with requests masked", r, 16'h0066);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule